// File: doc/BRIEF.md
# Prescaled Timer/Counter with Compare Interrupts

This block is a timer/counter peripheral that sits on an 8-bit byte-wide register bus of a small microcontroller. The count is 8 or 16 bits wide, set by a parameter. A clock-select field picks a prescale ratio for the counter. A two-bit wave-mode field chooses one of four counting schemes: free-running, clear-on-compare-A, fast PWM and up/down (triangle) PWM. Two compare channels watch the count. Each channel raises a flag on a match and can drive an output pin with a toggle, clear or set action.

There are three event flags: overflow, compare A and compare B. Each flag has a mask bit. A request output stays high while a flag and its mask bit are both set. Software clears a flag by writing 1 to it. The CPU's per-source acknowledge strobe also clears it. Wide registers are read and written through one shared 8-bit high-byte holding register. A write to the count does not take effect at once: it waits for the next prescaled step.

Top module: `tmr_unit`

## Requirements
- R1: After reset, the count, both compare values, the flags (address 8) and the masks (address 9) read as zero, and all request and pin outputs are low.
- R2: Writes to the high-byte addresses (count 3, compare A 5, compare B 7) go into the holding register. A write to the matching low-byte address (2, 4, 6) commits {holding, data}. Reading the count low byte (address 2) copies the count's high byte into the holding register, and reading address 3 returns that copy.
- R3: A count write is kept as a pending value and the direction is set to up. The pending value is loaded at the next prescaled step. That loading step raises no compare or overflow event.
- R4: Bits [2:0] of address 1 select the step ratio: 0 stops the counter, then 1→1, 2→8, 3→64, 4→256, 5→1024, and 6 and 7 stop it. Any write to address 1 restarts the prescale phase.
- R5: In free-running mode (address 0 bits [1:0] = 0) and fast PWM (= 2), the count steps up by one. The step from all ones to zero sets the overflow flag (bit 0).
- R6: When the stepped count equals a nonzero compare value, flag bit 1 is set for channel A and flag bit 2 for channel B. A compare value of zero never matches.
- R7: In clear-on-compare mode (= 1), a channel A match loads zero into the count and sets both the overflow flag and the compare-A flag.
- R8: In triangle mode (= 3), the count rises to all ones, then falls. Reaching zero while falling sets the overflow flag and turns the count upward. Reaching the top sets no flag.
- R9: Writing address 8 clears each flag whose data bit is 1 and leaves the others. An acknowledge strobe clears its own flag. A new event in the same cycle wins over a clear.
- R10: Each request output is high exactly when its flag bit and the mask bit at the same position in address 9 are both 1.
- R11: On a match, channel A applies the action in address 0 bits [3:2] and channel B the action in bits [5:4]: 0 keeps the pin, 1 toggles it, 2 clears it, 3 sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| ack_ovf | input | 1 | Acknowledge, clears the overflow flag |
| ack_cmp_a | input | 1 | Acknowledge, clears the compare-A flag |
| ack_cmp_b | input | 1 | Acknowledge, clears the compare-B flag |
| irq_ovf | output | 1 | Overflow request |
| irq_cmp_a | output | 1 | Compare-A request |
| irq_cmp_b | output | 1 | Compare-B request |
| wave_a | output | 1 | Channel A pin |
| wave_b | output | 1 | Channel B pin |

## Verification
The checker assumes that bus strobes and acknowledge strobes are synchronous and last one cycle each. It also assumes that a count write never arrives in the same cycle as a prescaled step. The load and hold properties rely on both. The bench drives every input on the falling edge and stops the counter before it writes or reads the count. It starts the counter again only through the clock-select register, so each run has a step count that can be predicted exactly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    WM_FREE     = 2'd0,
    WM_CLR_ON_A = 2'd1,
    WM_FAST     = 2'd2,
    WM_TRIANGLE = 2'd3
  } wave_mode_e;

  typedef enum logic [1:0] {
    PA_NONE   = 2'd0,
    PA_TOGGLE = 2'd1,
    PA_CLEAR  = 2'd2,
    PA_SET    = 2'd3
  } pin_act_e;

  localparam int ADDR_W = 4;
  localparam int PRE_W  = 10;

  localparam logic [ADDR_W-1:0] A_CTLA   = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTLB   = 4'd1;
  localparam logic [ADDR_W-1:0] A_CNT_L  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CNT_H  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CMPA_L = 4'd4;
  localparam logic [ADDR_W-1:0] A_CMPA_H = 4'd5;
  localparam logic [ADDR_W-1:0] A_CMPB_L = 4'd6;
  localparam logic [ADDR_W-1:0] A_CMPB_H = 4'd7;
  localparam logic [ADDR_W-1:0] A_FLAG   = 4'd8;
  localparam logic [ADDR_W-1:0] A_MASK   = 4'd9;

  // Step ratio for a clock-select code; zero means stopped.
  function automatic logic [PRE_W:0] step_ratio(input logic [2:0] sel);
    case (sel)
      3'd1:    return (PRE_W+1)'(1);
      3'd2:    return (PRE_W+1)'(8);
      3'd3:    return (PRE_W+1)'(64);
      3'd4:    return (PRE_W+1)'(256);
      3'd5:    return (PRE_W+1)'(1024);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale import tmr_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       restart,
  output logic       tick
);

  logic [PRE_W-1:0] ph_q, ph_d;
  logic [PRE_W:0]   ratio;

  always_comb begin
    ratio = step_ratio(sel);
    tick  = (ratio != '0) && ({1'b0, ph_q} == ratio - 1'b1);
    ph_d  = ph_q;
    if (restart || tick)    ph_d = '0;
    else if (ratio != '0)   ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

endmodule

// File: rtl/tmr_core.sv
module tmr_core import tmr_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  wave_mode_e       mode,
  input  pin_act_e         act_a,
  input  pin_act_e         act_b,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt,
  output logic             pend_vld,
  output logic [CNT_W-1:0] pend_val,
  output logic             hit_ovf,
  output logic             hit_a,
  output logic             hit_b,
  output logic             pin_a,
  output logic             pin_b
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, pval_q, pval_d, step;
  logic             up_q, up_d, up_step, pend_q, pend_d;
  logic             pa_q, pa_d, pb_q, pb_d;
  logic             wrap, bottom, adv, clr;

  function automatic logic pin_next(input logic cur, input pin_act_e act);
    case (act)
      PA_TOGGLE: return !cur;
      PA_CLEAR:  return 1'b0;
      PA_SET:    return 1'b1;
      default:   return cur;
    endcase
  endfunction

  always_comb begin
    step    = cnt_q + 1'b1;
    up_step = up_q;
    wrap    = 1'b0;
    bottom  = 1'b0;
    if (mode == WM_TRIANGLE) begin
      if (up_q && cnt_q == TOP) begin
        up_step = 1'b0;
        step    = cnt_q - 1'b1;
      end else if (!up_q) begin
        step = cnt_q - 1'b1;
        if (step == '0) begin
          up_step = 1'b1;
          bottom  = 1'b1;
        end
      end
    end else begin
      wrap = (cnt_q == TOP) && (mode != WM_CLR_ON_A);
    end

    adv     = tick && !pend_q;
    hit_a   = adv && (cmp_a != '0) && (step == cmp_a);
    hit_b   = adv && (cmp_b != '0) && (step == cmp_b);
    clr     = hit_a && (mode == WM_CLR_ON_A);
    hit_ovf = adv && (wrap || bottom || clr);

    cnt_d = cnt_q;
    up_d  = up_q;
    if (tick && pend_q) begin
      cnt_d = pval_q;
      up_d  = 1'b1;
    end else if (adv) begin
      cnt_d = clr ? '0 : step;
      up_d  = up_step;
    end
    if (wr_cnt) up_d = 1'b1;

    pend_d = pend_q;
    pval_d = pval_q;
    if (wr_cnt) begin
      pend_d = 1'b1;
      pval_d = wr_val;
    end else if (tick) begin
      pend_d = 1'b0;
    end

    pa_d = hit_a ? pin_next(pa_q, act_a) : pa_q;
    pb_d = hit_b ? pin_next(pb_q, act_b) : pb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      pend_q <= 1'b0;
      pval_q <= '0;
      pa_q   <= 1'b0;
      pb_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      up_q   <= up_d;
      pend_q <= pend_d;
      pval_q <= pval_d;
      pa_q   <= pa_d;
      pb_q   <= pb_d;
    end
  end

  assign cnt      = cnt_q;
  assign pend_vld = pend_q;
  assign pend_val = pval_q;
  assign pin_a    = pa_q;
  assign pin_b    = pb_q;

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs import tmr_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              hit_ovf,
  input  logic              hit_a,
  input  logic              hit_b,
  input  logic [2:0]        ack,
  output wave_mode_e        mode,
  output pin_act_e          act_a,
  output pin_act_e          act_b,
  output logic [2:0]        sel,
  output logic              restart,
  output logic [CNT_W-1:0]  cmp_a,
  output logic [CNT_W-1:0]  cmp_b,
  output logic              wr_cnt,
  output logic [CNT_W-1:0]  wr_val,
  output logic [2:0]        flags,
  output logic [2:0]        mask
);

  logic [5:0]       ctla_q, ctla_d;
  logic [2:0]       sel_q, sel_d, flag_q, flag_d, mask_q, mask_d, flag_clr;
  logic [7:0]       tmp_q, tmp_d;
  logic [CNT_W-1:0] cmpa_q, cmpa_d, cmpb_q, cmpb_d;
  logic [15:0]      full, cnt_x, cmpa_x, cmpb_x;

  assign full   = {tmp_q, wr_data};
  assign cnt_x  = 16'(cnt);
  assign cmpa_x = 16'(cmpa_q);
  assign cmpb_x = 16'(cmpb_q);

  always_comb begin
    ctla_d   = ctla_q;
    sel_d    = sel_q;
    tmp_d    = tmp_q;
    cmpa_d   = cmpa_q;
    cmpb_d   = cmpb_q;
    mask_d   = mask_q;
    restart  = 1'b0;
    wr_cnt   = 1'b0;
    flag_clr = ack;
    if (rd_en && addr == A_CNT_L) tmp_d = cnt_x[15:8];
    if (wr_en) begin
      case (addr)
        A_CTLA:   ctla_d = wr_data[5:0];
        A_CTLB: begin
          sel_d   = wr_data[2:0];
          restart = 1'b1;
        end
        A_CNT_H, A_CMPA_H, A_CMPB_H: tmp_d = wr_data;
        A_CNT_L:  wr_cnt = 1'b1;
        A_CMPA_L: cmpa_d = full[CNT_W-1:0];
        A_CMPB_L: cmpb_d = full[CNT_W-1:0];
        A_FLAG:   flag_clr = ack | wr_data[2:0];
        A_MASK:   mask_d = wr_data[2:0];
        default: ;
      endcase
    end
    flag_d = (flag_q & ~flag_clr) | {hit_b, hit_a, hit_ovf};

    rd_data = '0;
    if (rd_en) begin
      case (addr)
        A_CTLA:   rd_data = {2'b00, ctla_q};
        A_CTLB:   rd_data = {5'b0, sel_q};
        A_CNT_L:  rd_data = cnt_x[7:0];
        A_CNT_H:  rd_data = tmp_q;
        A_CMPA_L: rd_data = cmpa_x[7:0];
        A_CMPA_H: rd_data = cmpa_x[15:8];
        A_CMPB_L: rd_data = cmpb_x[7:0];
        A_CMPB_H: rd_data = cmpb_x[15:8];
        A_FLAG:   rd_data = {5'b0, flag_q};
        A_MASK:   rd_data = {5'b0, mask_q};
        default:  rd_data = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctla_q <= '0;
      sel_q  <= '0;
      tmp_q  <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      ctla_q <= ctla_d;
      sel_q  <= sel_d;
      tmp_q  <= tmp_d;
      cmpa_q <= cmpa_d;
      cmpb_q <= cmpb_d;
      flag_q <= flag_d;
      mask_q <= mask_d;
    end
  end

  assign mode   = wave_mode_e'(ctla_q[1:0]);
  assign act_a  = pin_act_e'(ctla_q[3:2]);
  assign act_b  = pin_act_e'(ctla_q[5:4]);
  assign sel    = sel_q;
  assign cmp_a  = cmpa_q;
  assign cmp_b  = cmpb_q;
  assign wr_val = full[CNT_W-1:0];
  assign flags  = flag_q;
  assign mask   = mask_q;

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit import tmr_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic              ack_ovf,
  input  logic              ack_cmp_a,
  input  logic              ack_cmp_b,
  output logic              irq_ovf,
  output logic              irq_cmp_a,
  output logic              irq_cmp_b,
  output logic              wave_a,
  output logic              wave_b
);

  wave_mode_e       mode;
  pin_act_e         act_a, act_b;
  logic [2:0]       sel, flags, mask, ack;
  logic             restart, tick, wr_cnt, pend_vld, hit_ovf, hit_a, hit_b;
  logic [CNT_W-1:0] cmp_a, cmp_b, wr_val, cnt, pend_val;

  assign ack = {ack_cmp_b, ack_cmp_a, ack_ovf};

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr),
    .wr_data(bus_wdata), .rd_en(bus_rd), .rd_data(bus_rdata), .cnt(cnt),
    .hit_ovf(hit_ovf), .hit_a(hit_a), .hit_b(hit_b), .ack(ack),
    .mode(mode), .act_a(act_a), .act_b(act_b), .sel(sel), .restart(restart),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .wr_cnt(wr_cnt), .wr_val(wr_val),
    .flags(flags), .mask(mask)
  );

  tmr_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .sel(sel), .restart(restart), .tick(tick)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .act_a(act_a),
    .act_b(act_b), .cmp_a(cmp_a), .cmp_b(cmp_b), .wr_cnt(wr_cnt),
    .wr_val(wr_val), .cnt(cnt), .pend_vld(pend_vld), .pend_val(pend_val),
    .hit_ovf(hit_ovf), .hit_a(hit_a), .hit_b(hit_b), .pin_a(wave_a),
    .pin_b(wave_b)
  );

  assign irq_ovf   = flags[0] & mask[0];
  assign irq_cmp_a = flags[1] & mask[1];
  assign irq_cmp_b = flags[2] & mask[2];

endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk import tmr_pkg::*; #(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_cnt,
  input logic [CNT_W-1:0]  cnt,
  input logic              pend_vld,
  input logic [CNT_W-1:0]  pend_val,
  input logic              hit_a,
  input logic              hit_b,
  input wave_mode_e        mode,
  input logic [2:0]        flags,
  input logic [2:0]        ack,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wr_data
);

  // R3
  defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !tick) |=> (cnt == $past(cnt)) && pend_vld);

  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend_vld) |=> (cnt == $past(pend_val)));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  // R7
  ctc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && mode == WM_CLR_ON_A) |=> (cnt == '0) && flags[0] && flags[1]);

  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[1] && !hit_a) |=> !flags[1]);

  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_FLAG && wr_data[2] && !hit_b) |=> !flags[2]);

endmodule

bind tmr_unit tmr_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_cnt(wr_cnt), .cnt(cnt),
  .pend_vld(pend_vld), .pend_val(pend_val), .hit_a(hit_a), .hit_b(hit_b),
  .mode(mode), .flags(flags), .ack(ack), .wr_en(bus_wr), .addr(bus_addr),
  .wr_data(bus_wdata)
);

// File: tb/tmr_unit_test.sv
module tmr_unit_test;
  import tmr_pkg::*;

  logic       clk, rst_n;
  logic [3:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic       ack_ovf, ack_cmp_a, ack_cmp_b;
  logic       irq_ovf, irq_cmp_a, irq_cmp_b, wave_a, wave_b;
  int         n_cmp = 0;
  int         n_bad = 0;

  tmr_unit #(.CNT_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ack_ovf(ack_ovf), .ack_cmp_a(ack_cmp_a), .ack_cmp_b(ack_cmp_b),
    .irq_ovf(irq_ovf), .irq_cmp_a(irq_cmp_a), .irq_cmp_b(irq_cmp_b),
    .wave_a(wave_a), .wave_b(wave_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // All bus tasks start and end on a falling edge, consuming one rising edge.
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] lo, input logic [15:0] v);
    wr(lo + 4'd1, v[15:8]);
    wr(lo, v[7:0]);
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] l, h;
    rd(A_CNT_L, l);
    rd(A_CNT_H, h);
    v = {h, l};
  endtask

  task automatic rd_flags(output logic [7:0] f);
    rd(A_FLAG, f);
  endtask

  // Runs at ratio 1 for exactly n+1 steps, then stops.
  task automatic run(input int n);
    wr(A_CTLB, 8'd1);
    repeat (n) @(negedge clk);
    wr(A_CTLB, 8'd0);
  endtask

  task automatic t_reset;
    logic [15:0] c; logic [7:0] f;
    rd_cnt(c);            chk("R1", "count", c, 16'h0);
    rd(A_CMPA_L, f);      chk("R1", "cmpA low", f, 8'h0);
    rd_flags(f);          chk("R1", "flags", f, 8'h0);
    rd(A_MASK, f);        chk("R1", "mask", f, 8'h0);
    chk("R1", "irqs", {irq_ovf, irq_cmp_a, irq_cmp_b}, 3'b000);
    chk("R1", "pins", {wave_a, wave_b}, 2'b00);
  endtask

  task automatic t_access;
    logic [15:0] c; logic [7:0] l, h;
    wr16(A_CNT_L, 16'h1234);
    run(0);
    rd_cnt(c);            chk("R2", "count via holding byte", c, 16'h1234);
    wr16(A_CMPA_L, 16'hABCD);
    rd(A_CMPA_L, l); rd(A_CMPA_H, h);
    chk("R2", "cmpA 16-bit write", {h, l}, 16'hABCD);
    wr16(A_CMPA_L, 16'h0000);
  endtask

  task automatic t_defer;
    logic [15:0] c; logic [7:0] f;
    wr16(A_CNT_L, 16'h0050);
    repeat (5) @(negedge clk);
    rd_cnt(c);            chk("R3", "count unchanged while stopped", c, 16'h1234);
    run(3);
    rd_cnt(c);            chk("R3", "loaded then stepped", c, 16'h0053);
    rd_flags(f);          chk("R3", "no event from load", f, 8'h0);
  endtask

  task automatic t_overflow;
    logic [15:0] c; logic [7:0] f;
    wr(A_FLAG, 8'h07); wr(A_CTLA, 8'h00);
    wr16(A_CNT_L, 16'hFFFE);
    run(2);
    rd_cnt(c);            chk("R5", "wrapped count", c, 16'h0000);
    rd_flags(f);          chk("R5", "overflow flag", f, 8'h01);
    chk("R10", "masked request low", irq_ovf, 1'b0);
    wr(A_MASK, 8'h01);
    chk("R10", "unmasked request high", irq_ovf, 1'b1);
    ack_ovf = 1'b1; @(negedge clk); ack_ovf = 1'b0;
    chk("R9", "ack clears request", irq_ovf, 1'b0);
    rd_flags(f);          chk("R9", "ack clears flag", f, 8'h00);
    wr(A_CTLA, 8'h02);
    wr16(A_CNT_L, 16'hFFFF);
    run(1);
    rd_cnt(c);            chk("R5", "fast PWM wrap", c, 16'h0000);
    chk("R5", "fast PWM overflow request", irq_ovf, 1'b1);
    wr(A_MASK, 8'h00); wr(A_FLAG, 8'h07);
  endtask

  task automatic t_compare;
    logic [15:0] c; logic [7:0] f;
    wr(A_CTLA, 8'h00);
    wr16(A_CMPA_L, 16'h0010);
    wr16(A_CMPB_L, 16'h0008);
    wr16(A_CNT_L, 16'h0005);
    run(7);
    rd_cnt(c);            chk("R6", "count at 0x0C", c, 16'h000C);
    rd_flags(f);          chk("R6", "only B matched", f, 8'h04);
    run(3);
    rd_flags(f);          chk("R6", "A matched too", f, 8'h06);
    wr(A_FLAG, 8'h02);
    rd_flags(f);          chk("R9", "write-1 clears only A", f, 8'h04);
    wr16(A_CMPA_L, 16'h0000);
    wr16(A_CMPB_L, 16'h0000);
    wr(A_FLAG, 8'h07);
    wr16(A_CNT_L, 16'hFFFE);
    run(3);
    rd_cnt(c);            chk("R6", "count past zero", c, 16'h0001);
    rd_flags(f);          chk("R6", "zero compare never matches", f, 8'h01);
    wr(A_FLAG, 8'h07);
  endtask

  task automatic t_ctc;
    logic [15:0] c; logic [7:0] f;
    wr(A_CTLA, 8'h35);    // B set, A toggle, clear-on-compare mode
    wr16(A_CMPA_L, 16'h0005);
    wr16(A_CMPB_L, 16'h0003);
    wr16(A_CNT_L, 16'h0000);
    run(7);
    rd_cnt(c);            chk("R7", "count restarted", c, 16'h0002);
    rd_flags(f);          chk("R7", "ovf and both compares", f, 8'h07);
    chk("R11", "A toggled high", wave_a, 1'b1);
    chk("R11", "B set", wave_b, 1'b1);
    run(5);
    rd_cnt(c);            chk("R7", "second period", c, 16'h0003);
    chk("R11", "A toggled low", wave_a, 1'b0);
    chk("R11", "B stays set", wave_b, 1'b1);
    wr16(A_CMPA_L, 16'h0000);
    wr16(A_CMPB_L, 16'h0000);
    wr(A_FLAG, 8'h07);
  endtask

  task automatic t_triangle;
    logic [15:0] c; logic [7:0] f;
    wr(A_CTLA, 8'h03);
    wr16(A_CNT_L, 16'hFFFE);
    run(2);
    rd_cnt(c);            chk("R8", "turned down at top", c, 16'hFFFE);
    rd_flags(f);          chk("R8", "no flag at top", f, 8'h00);
    run(65535);
    rd_cnt(c);            chk("R8", "turned up at zero", c, 16'h0002);
    rd_flags(f);          chk("R8", "overflow at zero", f, 8'h01);
    wr(A_FLAG, 8'h07);
    wr(A_CTLA, 8'h00);
  endtask

  task automatic t_prescale;
    logic [15:0] c;
    wr16(A_CNT_L, 16'h0100);
    wr(A_CTLB, 8'd2);
    repeat (16) @(negedge clk);
    wr(A_CTLB, 8'd0);
    rd_cnt(c);            chk("R4", "ratio 8 gives two steps", c, 16'h0101);
    wr16(A_CNT_L, 16'h0200);
    wr(A_CTLB, 8'd7);
    repeat (20) @(negedge clk);
    wr(A_CTLB, 8'd0);
    rd_cnt(c);            chk("R4", "code 7 stops", c, 16'h0101);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    ack_ovf = 1'b0; ack_cmp_a = 1'b0; ack_cmp_b = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_access;
    t_defer;
    t_overflow;
    t_compare;
    t_ctc;
    t_triangle;
    t_prescale;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL all: watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule